// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block stretches accesses on a memory bus whose address space is divided into sixteen regions, picked by the top four address bits. For each access it receives the region number, whether the access is a 16-bit or 32-bit transfer, and whether it follows the previous access sequentially. It then holds `ready` low for the matching number of wait cycles and raises it for one cycle to complete the access.

A 16-bit control register sets the costs of three external ROM windows and one save-RAM window. Each ROM window covers a base region and the region after it. Each window has a two-bit code for the first-access cost and its own one-bit code for the sequential cost. Save RAM takes one two-bit code that serves both access kinds. A 32-bit transfer is charged as two halfword transfers back to back. A second, purely combinational lookup port gives a prefetch unit the non-sequential 16-bit and 32-bit costs of any region it names, together with the prefetch-enable bit of the register.

Top module: `wsg_top`

## Requirements
- R1: A first-access code of 0, 1, 2 or 3 gives 4, 3, 2 or 8 waits. The code sits in bits 3:2 for ROM window 0 (regions 8 and 9), in bits 6:5 for window 1 (regions 10 and 11), in bits 9:8 for window 2 (regions 12 and 13), and in bits 1:0 for save RAM (region 14).
- R2: The sequential 16-bit cost of a window is set by bit 4 (window 0), bit 7 (window 1) or bit 10 (window 2). A value of 1 gives 1 wait. A value of 0 gives 2, 4 or 8 waits for windows 0, 1 and 2.
- R3: A 32-bit access costs first + sequential + 1 when it is non-sequential and 2 × sequential + 1 when it is sequential. First and sequential are the region's 16-bit costs, and the rule applies in every region.
- R4: In region 14 the sequential 16-bit cost equals the non-sequential 16-bit cost, both set by bits 1:0.
- R5: The two regions of a ROM window always carry identical costs for every access kind.
- R6: After reset the register holds 0 and `prefetch_en` is 0. Region 2 costs 2 waits for both 16-bit kinds. Regions 0, 1, 3–7 and 15 cost 0 waits for 16-bit accesses. Regions 8–14 follow R1 and R2 with every field at 0.
- R7: A request to a zero-cost access raises `ready` combinationally in the cycle the request is presented, and no wait is entered.
- R8: A request to an access of cost N > 0 keeps `ready` low for exactly N cycles, counting the request cycle. `ready` is then high for one cycle, after which the block is idle again.
- R9: While a wait is in progress, `req_valid` and the request fields are ignored, and so is a register write. The wait in progress finishes with the cost latched when its request was accepted.
- R10: A register write takes effect in the next cycle: `prefetch_en` shows bit 14, and `pf_cost16`/`pf_cost32` show the new non-sequential costs of `pf_region`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 16 | Control register write data |
| req_valid | input | 1 | Access request |
| req_region | input | 4 | Region of the access |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| req_seq | input | 1 | 1 = sequential access |
| ready | output | 1 | Access completes in this cycle |
| pf_region | input | 4 | Region queried by the prefetch unit |
| pf_cost16 | output | 5 | Non-sequential 16-bit cost of pf_region |
| pf_cost32 | output | 5 | Non-sequential 32-bit cost of pf_region |
| prefetch_en | output | 1 | Prefetch enable bit of the register |

## Verification
The hardest case to reach is a wait in progress while the inputs that set its length change under it. This covers a new request to a zero-cost region and a register write that would shorten the same access. Reaching it means holding a long access open and then, in the cycle after it is accepted, driving both a new request and a register write together. The bench then checks that the wait still lasts the originally latched count, and that the register change shows up only in the access that follows.

// File: rtl/wsg_pkg.sv
// Shared types and cost arithmetic for the wait-state generator.
// Assumes sixteen regions and wait values that fit in WAIT_W bits.
package wsg_pkg;
    localparam int REGION_N    = 16;
    localparam int REGION_W    = $clog2(REGION_N);
    localparam int WAIT_W      = 4;
    localparam int COST_W      = WAIT_W + 1;
    localparam int CFG_W       = 16;
    localparam int FAST_REGION = 2;
    localparam int ROM_BASE    = 8;
    localparam int ROM_WINDOWS = 3;
    localparam int SRAM_REGION = 14;
    localparam int PF_BIT      = 14;

    typedef struct packed {
        logic [WAIT_W-1:0] first;
        logic [WAIT_W-1:0] seq;
    } wait_pair_t;

    // Two-bit first-access code to wait count.
    function automatic logic [WAIT_W-1:0] first_wait(input logic [1:0] code);
        case (code)
            2'd0:    first_wait = WAIT_W'(4);
            2'd1:    first_wait = WAIT_W'(3);
            2'd2:    first_wait = WAIT_W'(2);
            default: first_wait = WAIT_W'(8);
        endcase
    endfunction

    // Cost of one access given the region's 16-bit pair, width and sequential flag.
    function automatic logic [COST_W-1:0] access_cost(input wait_pair_t p,
                                                      input logic wide,
                                                      input logic seq);
        logic [COST_W-1:0] f;
        logic [COST_W-1:0] s;
        f = COST_W'(p.first);
        s = COST_W'(p.seq);
        if (!wide)
            access_cost = seq ? s : f;
        else if (seq)
            access_cost = s + s + COST_W'(1);
        else
            access_cost = f + s + COST_W'(1);
    endfunction
endpackage

// File: rtl/wsg_cfg_reg.sv
// Control register: holds the 16-bit wait configuration.
// Assumes a single writer; the write lands on the next clock edge.
module wsg_cfg_reg
    import wsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg
);
    // Capture writes, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (we)
            cfg <= wdata;
    end
endmodule

// File: rtl/wsg_region_table.sv
// Per-region 16-bit wait pairs derived from the control register.
// One generate branch per region class; regions outside every class cost 0.
module wsg_region_table
    import wsg_pkg::*;
(
    input  logic [CFG_W-1:0]                cfg,
    output wait_pair_t [REGION_N-1:0]       tbl
);
    for (genvar r = 0; r < REGION_N; r++) begin : g_region
        if (r == FAST_REGION) begin : g_fast
            // Fixed two-wait region.
            assign tbl[r] = '{first: WAIT_W'(2), seq: WAIT_W'(2)};
        end else if (r >= ROM_BASE && r < ROM_BASE + 2 * ROM_WINDOWS) begin : g_rom
            localparam int WIN     = (r - ROM_BASE) / 2;
            localparam int CODE_LO = 2 + 3 * WIN;
            localparam int SEQ_BIT = 4 + 3 * WIN;
            // Window decode shared by both regions of the window.
            assign tbl[r].first = first_wait(cfg[CODE_LO +: 2]);
            assign tbl[r].seq   = cfg[SEQ_BIT] ? WAIT_W'(1) : WAIT_W'(2 << WIN);
        end else if (r == SRAM_REGION) begin : g_sram
            // Save RAM: one value for both access kinds.
            assign tbl[r].first = first_wait(cfg[1:0]);
            assign tbl[r].seq   = first_wait(cfg[1:0]);
        end else begin : g_none
            assign tbl[r] = '0;
        end
    end
endmodule

// File: rtl/wsg_wait_counter.sv
// Wait counter: loads cost-1 on an accepted request and counts down to 0.
// Assumes the cost is valid in the cycle req_valid is presented while idle.
module wsg_wait_counter
    import wsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [COST_W-1:0] cost,
    output logic              ready,
    output logic              busy,
    output logic [COST_W-1:0] cnt
);
    // Accept, count down and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (req_valid && cost != '0) begin
                busy <= 1'b1;
                cnt  <= cost - COST_W'(1);
            end
        end else if (cnt == '0) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt - COST_W'(1);
        end
    end

    // Completion strobe.
    always_comb begin
        if (busy)
            ready = (cnt == '0);
        else
            ready = req_valid && (cost == '0);
    end
endmodule

// File: rtl/wsg_top.sv
// Wait-state generator top: register, region table, cost lookups, counter.
// Assumes the requester holds req_* stable in the cycle it presents them.
module wsg_top
    import wsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic [REGION_W-1:0] req_region,
    input  logic              req_wide,
    input  logic              req_seq,
    output logic              ready,
    input  logic [REGION_W-1:0] pf_region,
    output logic [COST_W-1:0] pf_cost16,
    output logic [COST_W-1:0] pf_cost32,
    output logic              prefetch_en
);
    logic [CFG_W-1:0]          cfg;
    wait_pair_t [REGION_N-1:0] tbl;
    logic [COST_W-1:0]         req_cost;
    logic                      busy;
    logic [COST_W-1:0]         cnt;

    wsg_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    wsg_region_table u_tbl (
        .cfg (cfg),
        .tbl (tbl)
    );

    // Cost of the presented request and the prefetch query.
    always_comb begin
        req_cost  = access_cost(tbl[req_region], req_wide, req_seq);
        pf_cost16 = access_cost(tbl[pf_region], 1'b0, 1'b0);
        pf_cost32 = access_cost(tbl[pf_region], 1'b1, 1'b0);
    end

    assign prefetch_en = cfg[PF_BIT];

    wsg_wait_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .cost      (req_cost),
        .ready     (ready),
        .busy      (busy),
        .cnt       (cnt)
    );
endmodule

// File: rtl/wsg_checker.sv
// Protocol checks for wsg_top, attached by bind.
module wsg_checker
    import wsg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic              ready,
    input logic              busy,
    input logic [COST_W-1:0] cnt,
    input logic [COST_W-1:0] req_cost,
    input logic              prefetch_en
);
    assert_zero_no_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_cost == '0) |=> !busy);

    assert_first_cycle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_cost != '0) |-> !ready);

    assert_enter_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_cost != '0) |=> busy);

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ready) |=> !busy);

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ready) |=> (busy && cnt == COST_W'($past(cnt) - COST_W'(1))));

    assert_prefetch_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (prefetch_en == $past(cfg_wdata[PF_BIT])));
endmodule

bind wsg_top wsg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .ready       (ready),
    .busy        (busy),
    .cnt         (cnt),
    .req_cost    (req_cost),
    .prefetch_en (prefetch_en)
);

// File: tb/wsg_top_bench.sv
`timescale 1ns/1ps
module wsg_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_region = '0;
    logic        req_wide = 1'b0;
    logic        req_seq = 1'b0;
    logic        ready;
    logic [3:0]  pf_region = '0;
    logic [4:0]  pf_cost16;
    logic [4:0]  pf_cost32;
    logic        prefetch_en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wsg_top u_wsg_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_region(req_region), .req_wide(req_wide),
        .req_seq(req_seq), .ready(ready), .pf_region(pf_region),
        .pf_cost16(pf_cost16), .pf_cost32(pf_cost32), .prefetch_en(prefetch_en)
    );

    // Model of the requirement tables.
    function automatic int m_first(input int code);
        case (code)
            0: return 4;
            1: return 3;
            2: return 2;
            default: return 8;
        endcase
    endfunction

    function automatic int m_cost(input int rg, input bit wide, input bit seq, input logic [15:0] c);
        int f; int s;
        f = 0; s = 0;
        if (rg == 2) begin f = 2; s = 2; end
        else if (rg >= 8 && rg <= 13) begin
            int w;
            w = (rg - 8) / 2;
            f = m_first(int'((c >> (2 + 3 * w)) & 16'h3));
            if (c[4 + 3 * w]) s = 1;
            else s = (w == 0) ? 2 : (w == 1) ? 4 : 8;
        end else if (rg == 14) begin
            f = m_first(int'(c[1:0])); s = f;
        end
        if (!wide) return seq ? s : f;
        return seq ? (2 * s + 1) : (f + s + 1);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present one request and count the cycles ready stays low.
    task automatic measure(input int rg, input bit wide, input bit seq, output int waits);
        waits = 0;
        req_valid = 1'b1; req_region = 4'(rg); req_wide = wide; req_seq = seq;
        #1;
        if (ready) begin
            @(negedge clk);
            req_valid = 1'b0;
        end else begin
            waits = 1;
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            for (int k = 0; k < 40 && !ready; k++) begin
                waits++;
                @(negedge clk);
                #1;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R6 prefetch_en", int'(prefetch_en), 0);
        for (int r = 0; r < 16; r++) begin
            pf_region = 4'(r);
            #1;
            check($sformatf("R6 pf_cost16 region %0d", r), int'(pf_cost16), m_cost(r, 0, 0, 16'h0));
            check($sformatf("R6 pf_cost32 region %0d", r), int'(pf_cost32), m_cost(r, 1, 0, 16'h0));
        end
        begin
            int w;
            @(negedge clk);
            measure(2, 0, 1, w); check("R6 region 2 seq16", w, 2);
            measure(9, 0, 1, w); check("R6 region 9 seq16", w, 2);
        end
    endtask

    task automatic t_first_codes();
        int w;
        for (int win = 0; win < 3; win++)
            for (int code = 0; code < 4; code++) begin
                write_cfg(16'(code << (2 + 3 * win)));
                measure(8 + 2 * win, 0, 0, w);
                check($sformatf("R1 window %0d code %0d", win, code), w, m_first(code));
            end
        for (int code = 0; code < 4; code++) begin
            write_cfg(16'(code));
            measure(14, 0, 0, w);
            check($sformatf("R1 save RAM code %0d", code), w, m_first(code));
        end
    endtask

    task automatic t_seq_bits();
        int w;
        for (int win = 0; win < 3; win++)
            for (int b = 0; b < 2; b++) begin
                write_cfg(16'(b << (4 + 3 * win)));
                measure(8 + 2 * win, 0, 1, w);
                check($sformatf("R2 window %0d bit %0d", win, b), w, b ? 1 : (2 << win));
            end
    endtask

    task automatic t_wide();
        int w;
        write_cfg(16'h0060);
        measure(10, 1, 0, w); check("R3 window 1 wide nonseq", w, 13);
        measure(10, 1, 1, w); check("R3 window 1 wide seq", w, 9);
        measure(2, 1, 0, w);  check("R3 region 2 wide nonseq", w, 5);
        measure(0, 1, 1, w);  check("R3 region 0 wide seq", w, 1);
    endtask

    task automatic t_sram();
        int w;
        write_cfg(16'h0003);
        measure(14, 0, 0, w); check("R4 save RAM nonseq16", w, 8);
        measure(14, 0, 1, w); check("R4 save RAM seq16", w, 8);
        measure(14, 1, 1, w); check("R4 save RAM seq32", w, 17);
        measure(14, 1, 0, w); check("R4 save RAM nonseq32", w, 17);
    endtask

    task automatic t_pairs();
        logic [15:0] cfgs [3];
        int a; int b;
        cfgs[0] = 16'h05AD; cfgs[1] = 16'h0372; cfgs[2] = 16'h0694;
        for (int i = 0; i < 3; i++) begin
            write_cfg(cfgs[i]);
            for (int win = 0; win < 3; win++)
                for (int k = 0; k < 4; k++) begin
                    measure(8 + 2 * win, k[1], k[0], a);
                    measure(9 + 2 * win, k[1], k[0], b);
                    check($sformatf("R5 cfg %h window %0d kind %0d base", cfgs[i], win, k), a,
                          m_cost(8 + 2 * win, k[1], k[0], cfgs[i]));
                    check($sformatf("R5 cfg %h window %0d kind %0d ext", cfgs[i], win, k), b, a);
                end
        end
    endtask

    task automatic t_zero();
        int w;
        req_valid = 1'b1; req_region = 4'd5; req_wide = 1'b0; req_seq = 1'b0;
        #1;
        check("R7 ready with zero-cost request", int'(ready), 1);
        @(negedge clk);
        #1;
        check("R7 still no wait next cycle", int'(ready), 1);
        req_valid = 1'b0;
        @(negedge clk);
        measure(15, 0, 1, w); check("R7 region 15 seq16", w, 0);
    endtask

    task automatic t_wait_len();
        int w;
        write_cfg(16'h0200);
        measure(12, 0, 0, w); check("R8 wait length 2", w, 2);
        write_cfg(16'h0000);
        req_valid = 1'b1; req_region = 4'd13; req_wide = 1'b1; req_seq = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        w = 1;
        #1;
        for (int k = 0; k < 40 && !ready; k++) begin
            w++;
            @(negedge clk);
            #1;
        end
        check("R8 wait length 17", w, 17);
        @(negedge clk);
        #1;
        check("R8 ready is a single cycle", int'(ready), 0);
    endtask

    task automatic t_busy_ignore();
        int w;
        write_cfg(16'h0300);
        req_valid = 1'b1; req_region = 4'd12; req_wide = 1'b0; req_seq = 1'b0;
        @(negedge clk);
        req_region = 4'd0;
        cfg_we = 1'b1; cfg_wdata = 16'h0200;
        w = 1;
        #1;
        for (int k = 0; k < 40 && !ready; k++) begin
            w++;
            @(negedge clk);
            cfg_we = 1'b0;
            #1;
        end
        cfg_we = 1'b0;
        check("R9 wait keeps latched cost", w, 8);
        req_valid = 1'b0;
        @(negedge clk);
        measure(12, 0, 0, w); check("R9 write applies to next access", w, 2);
    endtask

    task automatic t_prefetch();
        @(negedge clk);
        pf_region = 4'd10;
        cfg_we = 1'b1; cfg_wdata = 16'h40E0;
        #1;
        check("R10 old cost before edge", int'(pf_cost16), 4);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check("R10 prefetch_en set", int'(prefetch_en), 1);
        check("R10 pf_cost16 updated", int'(pf_cost16), 8);
        check("R10 pf_cost32 updated", int'(pf_cost32), 10);
        write_cfg(16'h0000);
        #1;
        check("R10 prefetch_en cleared", int'(prefetch_en), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_codes();
        t_seq_bits();
        t_wide();
        t_sram();
        t_pairs();
        t_zero();
        t_wait_len();
        t_busy_ignore();
        t_prefetch();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule